// File: doc/BRIEF.md
# Accumulator-Centric 16-bit Processor Core

A small multi-cycle 16-bit processor whose arithmetic always lands in register R0, the accumulator. Every instruction is one 16-bit word made of an operation code in bits 15:12, a register selector in bits 11:8 and an 8-bit payload in bits 7:0. The payload is either a zero-extended immediate or an absolute jump target in the range 0x00 to 0xFF. Reaching the rest of the address space takes a long jump, which reads its target from the word after it, or an indirect jump to the address held in R0.

The core fetches, loads and stores through one word-addressed memory port with a request/acknowledge handshake. The memory may insert any number of wait cycles. Subroutines use a 16-entry hardware return stack. Calling with the stack full, or returning with it empty, raises a sticky error flag and stops the core. A zero flag follows every value written into R0 and feeds two conditional branches. It is used as the control core of a larger design, running a program held in the memory behind its port.

Top module: `acc_cpu16`

## Requirements
- R1: While rst_n is low, mem_req, halted and stk_err are all 0. The first memory request after reset is a read (mem_we=0) of address 0x0000.
- R2: Instructions use opcode bits 15:12, register bits 11:8 and payload bits 7:0. SET (0xF) loads Rn with the zero-extended payload. GET (0x1) copies Rn into R0. PUT (0x2) copies R0 into Rn.
- R3: LDI (0x3) loads R0 from the memory word addressed by Rn. STI (0x4) writes R0 to the memory word addressed by Rn.
- R4: ADDI (0x5) adds the zero-extended payload to R0, and SUBI (0x6) subtracts it from R0, both modulo 2^16. The register field of both is ignored.
- R5: ALU (0x7) writes R0 with the operation that payload bits 2:0 select: 0 R0+Rn, 1 R0-Rn, 2 R0&Rn, 3 R0|Rn, 4 R0^Rn, 5 ~R0, 6 R0+1, 7 R0-1, all modulo 2^16.
- R6: JS (0x8) continues execution at the zero-extended payload address.
- R7: JL (0x9) continues at the address held in the word that follows it. That word is never executed as an instruction.
- R8: JA (0xA) continues at the 16-bit address held in R0.
- R9: Every write to R0 sets the zero flag exactly when the value written is 0. BZ (0xB) jumps to the payload address when the flag is 1, and BNZ (0xC) jumps there when it is 0. Otherwise both fall through to the next instruction.
- R10: CALL (0xD) saves the address of the next instruction and jumps to the payload address. RET (0xE) resumes at the most recently saved address. Calls nest 16 deep.
- R11: A CALL made while 16 return addresses are held sets stk_err and halted. Both stay set until reset, and no further memory request is issued.
- R12: A RET made while no return address is held sets stk_err and halted in the same way.
- R13: HALT (0x0) sets halted, which stays set until reset, and no further memory request is issued.
- R14: Once raised, mem_req stays high, with mem_addr, mem_we and mem_wdata unchanged, until the cycle in which mem_ack is 1. That cycle completes the access, and a store writes mem_wdata at mem_addr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = store, 0 = read |
| mem_addr | output | 16 | Word address of the access |
| mem_wdata | output | 16 | Store data |
| mem_rdata | input | 16 | Read data, valid while mem_ack is 1 |
| mem_ack | input | 1 | Access complete |
| halted | output | 1 | Core stopped by HALT or by a stack error |
| stk_err | output | 1 | Sticky return-stack overflow or underflow |

## Verification
The handshake properties assume that the memory raises mem_ack only while a request is pending, and only once for each access. The bench memory counts a chosen number of wait cycles on a held request, acknowledges for a single cycle and then drops the acknowledge. The wait count ranges from zero to three across runs. Programs are loaded while reset is held, so no access is ever answered for a request made before reset.

// File: rtl/acc_cpu16_pkg.sv
// Package: shared types for the accumulator core.
// Assumes a fixed 16-bit instruction word: op[15:12], reg[11:8], payload[7:0].
package acc_cpu16_pkg;

    localparam int WORD_W = 16;
    localparam int PAY_W  = 8;

    typedef enum logic [3:0] {
        OP_HALT  = 4'h0,
        OP_GET   = 4'h1,
        OP_PUT   = 4'h2,
        OP_LDIND = 4'h3,
        OP_STIND = 4'h4,
        OP_ADDI  = 4'h5,
        OP_SUBI  = 4'h6,
        OP_ALU   = 4'h7,
        OP_JS    = 4'h8,
        OP_JL    = 4'h9,
        OP_JA    = 4'hA,
        OP_BZ    = 4'hB,
        OP_BNZ   = 4'hC,
        OP_CALL  = 4'hD,
        OP_RET   = 4'hE,
        OP_SET   = 4'hF
    } opcode_e;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_XOR = 3'd4,
        ALU_INV = 3'd5,
        ALU_INC = 3'd6,
        ALU_DEC = 3'd7
    } alu_op_e;

    typedef enum logic [2:0] {
        ST_BOOT  = 3'd0,
        ST_FETCH = 3'd1,
        ST_EXEC  = 3'd2,
        ST_MEM   = 3'd3,
        ST_STOP  = 3'd4
    } state_e;

endpackage

// File: rtl/acc_cpu16_alu.sv
// Module: acc_cpu16_alu
// Combinational datapath for all accumulator arithmetic and logic.
// Assumes: a is always the accumulator; b is a register or a zero-extended payload.
module acc_cpu16_alu
    import acc_cpu16_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    // Select the result of the requested operation, wrapping modulo 2^W.
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_XOR: y = a ^ b;
            ALU_INV: y = ~a;
            ALU_INC: y = a + W'(1);
            ALU_DEC: y = a - W'(1);
            default: y = a;
        endcase
    end

endmodule

// File: rtl/acc_cpu16_regfile.sv
// Module: acc_cpu16_regfile
// General register file with one write port and one selectable read port.
// Register 0 is also exposed on its own output as the accumulator.
// Assumes: a write and a read of the same register in one cycle returns the old value.
module acc_cpu16_regfile
    import acc_cpu16_pkg::*;
#(
    parameter int NREG = 16,
    parameter int W    = WORD_W,
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [W-1:0]     wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [W-1:0]     rdata,
    output logic [W-1:0]     acc
);

    logic [W-1:0] regs [NREG];

    // Clear all registers on reset, otherwise perform the single write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    // Read ports.
    assign rdata = regs[raddr];
    assign acc   = regs[0];

endmodule

// File: rtl/acc_cpu16_rstack.sv
// Module: acc_cpu16_rstack
// LIFO of return addresses with full and empty indication.
// Assumes: the caller never pushes when full nor pops when empty.
module acc_cpu16_rstack
    import acc_cpu16_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int W     = WORD_W,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);

    logic [W-1:0]     slots [DEPTH];
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] top_idx;

    // Track the fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (push) begin
            cnt <= cnt + 1'b1;
        end else if (pop) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Store the pushed address in the next free slot.
    always_ff @(posedge clk) begin
        if (push) begin
            slots[IDX_W'(cnt)] <= din;
        end
    end

    // Flags and the most recently pushed entry.
    assign full    = (cnt == CNT_W'(DEPTH));
    assign empty   = (cnt == '0);
    assign top_idx = cnt - 1'b1;
    assign dout    = slots[IDX_W'(top_idx)];

endmodule

// File: rtl/acc_cpu16.sv
// Module: acc_cpu16
// Multi-cycle accumulator processor: fetch, execute and, for loads, stores
// and long jumps, one extra memory phase. All arithmetic writes R0.
// Assumes: mem_ack is raised only while mem_req is high, once per access,
// with mem_rdata valid in that cycle.
module acc_cpu16
    import acc_cpu16_pkg::*;
#(
    parameter int NREG        = 16,
    parameter int STACK_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              halted,
    output logic              stk_err
);

    localparam int RIDX_W = (NREG > 1) ? $clog2(NREG) : 1;

    state_e            state;
    logic [WORD_W-1:0] pc;
    logic [WORD_W-1:0] ir;
    logic              zflag;
    logic              err_q;

    // Decoded fields of the current instruction.
    opcode_e           op;
    logic [RIDX_W-1:0] rsel;
    logic [WORD_W-1:0] imm_ext;
    assign op      = opcode_e'(ir[15:12]);
    assign rsel    = ir[8 +: RIDX_W];
    assign imm_ext = {{(WORD_W-PAY_W){1'b0}}, ir[PAY_W-1:0]};

    // Register file connections.
    logic              rf_we;
    logic [RIDX_W-1:0] rf_waddr;
    logic [WORD_W-1:0] rf_wdata;
    logic [WORD_W-1:0] rn_val;
    logic [WORD_W-1:0] acc;

    acc_cpu16_regfile #(.NREG(NREG), .W(WORD_W)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata),
        .raddr (rsel),
        .rdata (rn_val),
        .acc   (acc)
    );

    // ALU operand and operation selection.
    alu_op_e           alu_op;
    logic [WORD_W-1:0] alu_b;
    logic [WORD_W-1:0] alu_y;

    // Immediate forms reuse the adder and subtractor with the payload as operand.
    always_comb begin
        unique case (op)
            OP_ADDI: begin alu_op = ALU_ADD; alu_b = imm_ext; end
            OP_SUBI: begin alu_op = ALU_SUB; alu_b = imm_ext; end
            default: begin alu_op = alu_op_e'(ir[2:0]); alu_b = rn_val; end
        endcase
    end

    acc_cpu16_alu #(.W(WORD_W)) u_alu (
        .op (alu_op),
        .a  (acc),
        .b  (alu_b),
        .y  (alu_y)
    );

    // Return stack connections.
    logic              stk_push;
    logic              stk_pop;
    logic [WORD_W-1:0] stk_top;
    logic              stk_full;
    logic              stk_empty;

    assign stk_push = (state == ST_EXEC) && (op == OP_CALL) && !stk_full;
    assign stk_pop  = (state == ST_EXEC) && (op == OP_RET) && !stk_empty;

    acc_cpu16_rstack #(.DEPTH(STACK_DEPTH), .W(WORD_W)) u_stk (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (stk_push),
        .pop   (stk_pop),
        .din   (pc),
        .dout  (stk_top),
        .full  (stk_full),
        .empty (stk_empty)
    );

    // Choose the register write for this cycle, if any.
    always_comb begin
        rf_we    = 1'b0;
        rf_waddr = '0;
        rf_wdata = acc;
        if (state == ST_EXEC) begin
            unique case (op)
                OP_SET: begin
                    rf_we    = 1'b1;
                    rf_waddr = rsel;
                    rf_wdata = imm_ext;
                end
                OP_GET: begin
                    rf_we    = 1'b1;
                    rf_wdata = rn_val;
                end
                OP_PUT: begin
                    rf_we    = 1'b1;
                    rf_waddr = rsel;
                    rf_wdata = acc;
                end
                OP_ADDI, OP_SUBI, OP_ALU: begin
                    rf_we    = 1'b1;
                    rf_wdata = alu_y;
                end
                default: ;
            endcase
        end else if ((state == ST_MEM) && mem_ack && (op == OP_LDIND)) begin
            rf_we    = 1'b1;
            rf_wdata = mem_rdata;
        end
    end

    // Track zero on every value written into the accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zflag <= 1'b0;
        end else if (rf_we && (rf_waddr == '0)) begin
            zflag <= (rf_wdata == '0);
        end
    end

    // Sequence the phases and update the program counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_BOOT;
            pc    <= '0;
            ir    <= '0;
            err_q <= 1'b0;
        end else begin
            unique case (state)
                ST_BOOT: state <= ST_FETCH;
                ST_FETCH: begin
                    if (mem_ack) begin
                        ir    <= mem_rdata;
                        pc    <= pc + 1'b1;
                        state <= ST_EXEC;
                    end
                end
                ST_EXEC: begin
                    state <= ST_FETCH;
                    unique case (op)
                        OP_HALT: state <= ST_STOP;
                        OP_LDIND, OP_STIND, OP_JL: state <= ST_MEM;
                        OP_JS: pc <= imm_ext;
                        OP_JA: pc <= acc;
                        OP_BZ: if (zflag) pc <= imm_ext;
                        OP_BNZ: if (!zflag) pc <= imm_ext;
                        OP_CALL: begin
                            if (stk_full) begin
                                err_q <= 1'b1;
                                state <= ST_STOP;
                            end else begin
                                pc <= imm_ext;
                            end
                        end
                        OP_RET: begin
                            if (stk_empty) begin
                                err_q <= 1'b1;
                                state <= ST_STOP;
                            end else begin
                                pc <= stk_top;
                            end
                        end
                        default: ;
                    endcase
                end
                ST_MEM: begin
                    if (mem_ack) begin
                        if (op == OP_JL) begin
                            pc <= mem_rdata;
                        end
                        state <= ST_FETCH;
                    end
                end
                ST_STOP: state <= ST_STOP;
                default: state <= ST_STOP;
            endcase
        end
    end

    // Drive the memory port from the current phase.
    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_addr = pc;
        if (state == ST_FETCH) begin
            mem_req = 1'b1;
        end else if (state == ST_MEM) begin
            mem_req  = 1'b1;
            mem_we   = (op == OP_STIND);
            mem_addr = (op == OP_JL) ? pc : rn_val;
        end
    end

    assign mem_wdata = acc;
    assign halted    = (state == ST_STOP);
    assign stk_err   = err_q;

endmodule

// File: rtl/acc_cpu16_chk.sv
// Module: acc_cpu16_chk
// Temporal checks on the port behaviour of acc_cpu16, attached by bind.
// Assumes: the memory acknowledges only pending requests.
module acc_cpu16_chk
    import acc_cpu16_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [WORD_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              mem_ack,
    input logic              halted,
    input logic              stk_err
);

    p_req_held_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_wdata_held_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_ack) |=> $stable(mem_wdata));

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stk_err |=> stk_err);

    p_err_stops_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stk_err) |-> halted);

    p_halt_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    p_halt_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_req);

endmodule

bind acc_cpu16 acc_cpu16_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .halted    (halted),
    .stk_err   (stk_err)
);

// File: tb/sim_acc_cpu16.sv
// Bench for acc_cpu16: a vector table of accumulator operations run through
// one program template, then directed programs for control flow and errors.
module sim_acc_cpu16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = 16'h0000;
    logic        mem_ack = 1'b0;
    logic        halted;
    logic        stk_err;

    int          n_total = 0;
    int          n_fail  = 0;
    int          lat     = 0;
    int          wcnt    = 0;
    logic [15:0] mem [1024];

    always #2 clk = ~clk;

    acc_cpu16 u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .halted    (halted),
        .stk_err   (stk_err)
    );

    // Memory model: waits lat cycles on a held request, then acknowledges once.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            wcnt    <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (wcnt == lat) begin
                mem_ack   <= 1'b1;
                wcnt      <= 0;
                mem_rdata <= mem[mem_addr[9:0]];
                if (mem_we) mem[mem_addr[9:0]] = mem_wdata;
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ins(input int op, input int r, input int pay);
        return {op[3:0], r[3:0], pay[7:0]};
    endfunction

    // Hold reset and clear memory so a new program can be written.
    task automatic begin_load();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
    endtask

    // Release reset and wait for the core to stop.
    task automatic run_to_halt(input string tag);
        int n;
        @(negedge clk);
        rst_n = 1'b1;
        n = 0;
        while (!halted && n < 4000) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " halted"}, {15'd0, halted}, 16'h0001);
    endtask

    // Store "halt, return" chain: n nested calls, leaf adds 1 to R0.
    task automatic build_nest(input int n);
        mem[0] = ins(15, 0, 0);
        mem[1] = ins(13, 0, 8'h60);
        mem[2] = ins(15, 1, 8'h98);
        mem[3] = ins(4, 1, 0);
        mem[4] = ins(0, 0, 0);
        for (int j = 0; j < n - 1; j++) begin
            mem[16'h60 + 2*j] = ins(13, 0, 8'h62 + 2*j);
            mem[16'h61 + 2*j] = ins(14, 0, 0);
        end
        mem[16'h60 + 2*(n-1)] = ins(5, 0, 1);
        mem[16'h61 + 2*(n-1)] = ins(14, 0, 0);
    endtask

    // Vector fields: instruction word, R0 operand, Rn operand, expected R0.
    localparam int NV = 12;
    localparam logic [63:0] VEC [NV] = '{
        {16'h7300, 16'h1234, 16'h0FFF, 16'h2233},
        {16'h7300, 16'hFFFF, 16'h0002, 16'h0001},
        {16'h7301, 16'h0005, 16'h0007, 16'hFFFE},
        {16'h7302, 16'hF0F0, 16'h3C3C, 16'h3030},
        {16'h7303, 16'hF0F0, 16'h3C3C, 16'hFCFC},
        {16'h7304, 16'hF0F0, 16'h3C3C, 16'hCCCC},
        {16'h7305, 16'hF0F0, 16'h0000, 16'h0F0F},
        {16'h7306, 16'hFFFF, 16'h0000, 16'h0000},
        {16'h7307, 16'h0000, 16'h0000, 16'hFFFF},
        {16'h5020, 16'hFFF0, 16'h0000, 16'h0010},
        {16'h60FF, 16'h0010, 16'h0000, 16'hFF11},
        {16'h5A80, 16'h0100, 16'h0000, 16'h0180}
    };

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 190000);
        n_total++;
        n_fail++;
        $display("FAIL R13 watchdog actual=running expected=halted");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        // R1 reset state, R14 held request under wait cycles.
        lat = 2;
        begin_load();
        mem[0] = ins(0, 0, 0);
        @(negedge clk);
        chk("R1 req in reset", {15'd0, mem_req}, 16'h0000);
        chk("R1 halted in reset", {15'd0, halted}, 16'h0000);
        chk("R1 stk_err in reset", {15'd0, stk_err}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 first req", {15'd0, mem_req}, 16'h0001);
        chk("R1 first addr", mem_addr, 16'h0000);
        chk("R1 first we", {15'd0, mem_we}, 16'h0000);
        @(negedge clk);
        chk("R14 req held", {15'd0, mem_req}, 16'h0001);
        chk("R14 addr held", mem_addr, 16'h0000);
        begin
            int n = 0;
            while (!halted && n < 100) begin @(negedge clk); n++; end
        end
        chk("R13 halted", {15'd0, halted}, 16'h0001);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk("R13 no req after halt", {15'd0, mem_req}, 16'h0000);
        end

        // R3 R4 R5 vector table through one load/operate/store template.
        for (int v = 0; v < NV; v++) begin
            lat = v % 4;
            begin_load();
            mem[0] = ins(15, 2, 8'h81);
            mem[1] = ins(3, 2, 0);
            mem[2] = ins(2, 3, 0);
            mem[3] = ins(15, 1, 8'h80);
            mem[4] = ins(3, 1, 0);
            mem[5] = VEC[v][63:48];
            mem[6] = ins(15, 4, 8'h90);
            mem[7] = ins(4, 4, 0);
            mem[8] = ins(0, 0, 0);
            mem[16'h80] = VEC[v][47:32];
            mem[16'h81] = VEC[v][31:16];
            run_to_halt("R3");
            chk((VEC[v][63:60] == 4'h7) ? "R5 alu result" : "R4 immediate result",
                mem[16'h90], VEC[v][15:0]);
        end

        // R2 register moves.
        lat = 1;
        begin_load();
        mem[0]  = ins(15, 5, 8'hA7);
        mem[1]  = ins(1, 5, 0);
        mem[2]  = ins(15, 6, 8'h91);
        mem[3]  = ins(4, 6, 0);
        mem[4]  = ins(15, 0, 8'h3C);
        mem[5]  = ins(2, 7, 0);
        mem[6]  = ins(15, 0, 8'h00);
        mem[7]  = ins(1, 7, 0);
        mem[8]  = ins(15, 1, 8'h92);
        mem[9]  = ins(4, 1, 0);
        mem[10] = ins(0, 0, 0);
        run_to_halt("R2");
        chk("R2 SET then GET", mem[16'h91], 16'h00A7);
        chk("R2 PUT then GET", mem[16'h92], 16'h003C);

        // R6 short jump.
        lat = 0;
        begin_load();
        mem[0] = ins(8, 0, 8'h10);
        mem[1] = ins(15, 0, 8'hEE); mem[2] = ins(15, 1, 8'h93); mem[3] = ins(4, 1, 0);
        mem[16'h10] = ins(15, 0, 8'h55); mem[16'h11] = ins(15, 1, 8'h93);
        mem[16'h12] = ins(4, 1, 0);
        run_to_halt("R6");
        chk("R6 short jump target", mem[16'h93], 16'h0055);

        // R7 long jump; the trailing word would halt if executed.
        lat = 3;
        begin_load();
        mem[0] = ins(9, 0, 0);
        mem[1] = 16'h0200;
        mem[2] = ins(15, 0, 8'hEE); mem[3] = ins(15, 1, 8'h94); mem[4] = ins(4, 1, 0);
        mem[16'h200] = ins(15, 0, 8'h77); mem[16'h201] = ins(15, 1, 8'h94);
        mem[16'h202] = ins(4, 1, 0);
        run_to_halt("R7");
        chk("R7 long jump target", mem[16'h94], 16'h0077);

        // R8 jump through the accumulator.
        lat = 1;
        begin_load();
        mem[0] = ins(15, 1, 8'h80);
        mem[1] = ins(3, 1, 0);
        mem[2] = ins(10, 0, 0);
        mem[3] = ins(15, 0, 8'hEE); mem[4] = ins(15, 1, 8'h95); mem[5] = ins(4, 1, 0);
        mem[16'h80] = 16'h0300;
        mem[16'h300] = ins(15, 0, 8'h88); mem[16'h301] = ins(15, 1, 8'h95);
        mem[16'h302] = ins(4, 1, 0);
        run_to_halt("R8");
        chk("R8 jump to R0", mem[16'h95], 16'h0088);

        // R9 zero flag: BZ taken, BNZ taken, BZ not taken.
        lat = 0;
        begin_load();
        mem[0] = ins(15, 0, 8'h01);
        mem[1] = ins(6, 0, 8'h01);
        mem[2] = ins(11, 0, 8'h20);
        mem[3] = ins(15, 0, 8'hEE); mem[4] = ins(15, 1, 8'h96); mem[5] = ins(4, 1, 0);
        mem[16'h20] = ins(15, 0, 8'h42);
        mem[16'h21] = ins(12, 0, 8'h30);
        mem[16'h22] = ins(15, 0, 8'hDD); mem[16'h23] = ins(15, 1, 8'h96);
        mem[16'h24] = ins(4, 1, 0);
        mem[16'h30] = ins(15, 1, 8'h96);
        mem[16'h31] = ins(11, 0, 8'h40);
        mem[16'h32] = ins(4, 1, 0);
        mem[16'h40] = ins(15, 0, 8'hCC); mem[16'h41] = ins(15, 1, 8'h96);
        mem[16'h42] = ins(4, 1, 0);
        run_to_halt("R9");
        chk("R9 branch path", mem[16'h96], 16'h0042);

        // R10 two calls to one subroutine.
        lat = 2;
        begin_load();
        mem[0] = ins(15, 0, 0);
        mem[1] = ins(13, 0, 8'h50);
        mem[2] = ins(13, 0, 8'h50);
        mem[3] = ins(15, 1, 8'h97);
        mem[4] = ins(4, 1, 0);
        mem[16'h50] = ins(5, 0, 3);
        mem[16'h51] = ins(14, 0, 0);
        run_to_halt("R10");
        chk("R10 call return result", mem[16'h97], 16'h0006);

        // R10 sixteen nested calls.
        lat = 0;
        begin_load();
        build_nest(16);
        run_to_halt("R10");
        chk("R10 nested 16 result", mem[16'h98], 16'h0001);
        chk("R10 nested 16 no error", {15'd0, stk_err}, 16'h0000);

        // R11 seventeenth nested call overflows.
        begin_load();
        build_nest(17);
        run_to_halt("R11");
        chk("R11 overflow error", {15'd0, stk_err}, 16'h0001);
        chk("R11 nothing stored", mem[16'h98], 16'h0000);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R11 no req after error", {15'd0, mem_req}, 16'h0000);
        end

        // R12 return with empty stack.
        begin_load();
        mem[0] = ins(14, 0, 0);
        mem[1] = ins(15, 0, 8'hEE); mem[2] = ins(15, 1, 8'h99); mem[3] = ins(4, 1, 0);
        run_to_halt("R12");
        chk("R12 underflow error", {15'd0, stk_err}, 16'h0001);
        chk("R12 nothing stored", mem[16'h99], 16'h0000);

        // R1 reset clears the sticky error.
        begin_load();
        @(negedge clk);
        chk("R1 error cleared by reset", {15'd0, stk_err}, 16'h0000);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule